// File: doc/BRIEF.md
# Multi-Latency Hazard Interlock

This block sits beside the decode stage of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) whose execute stage is split into pipelined functional units of different fixed depths. Each cycle it looks at the instruction held in decode: unit type, write enable, destination register and two source registers. It decides whether that instruction may leave decode, when its result may be written back, and which source operands should be captured now.

A record per architectural register holds the distance in cycles to the writeback of the youngest in-flight writer of that register. A source that is still too far from its value holds decode (read-after-write). A new writer that would overtake an older writer of the same register is pushed back so that the writebacks stay in program order (write-after-write). A source that is already available is read on the first decode cycle and latched, so a later writer cannot clobber it while the other source waits (write-after-read). A build-time switch chooses whether results may be forwarded from the last execute cycle or only taken from writeback. The stall cycles can then be compared between the two builds.

Top module: `hz_interlock`

## Requirements
- R1: Unit codes are 0 = add/subtract (execute depth 3), 1 = multiply (depth 5), 2 = divide (depth 8). A writer with no conflict raises bit `dst` of `wb_mask` exactly depth+2 cycles after the cycle in which it leaves decode.
- R2: While a nonzero source register has a pending writer that is not yet usable, `stall_id` is high and `issue` is low. With `id_valid` low, `stall_id` is low.
- R3: With `FWD_EN`=1 a dependent instruction may leave decode in the producer's last execute cycle, so back-to-back it stalls depth-1 cycles. With `FWD_EN`=0 it waits for the producer's writeback cycle, so back-to-back it stalls depth+1 cycles. `fwd_hit` pulses on an issue that relied on forwarding and never pulses when forwarding is disabled.
- R4: A writer that would write back before or in the same cycle as an older pending writer of the same register is delayed until the cycle after that older writeback. `stall_wb` is high for each delay cycle, and only one writeback pulse appears for the register.
- R5: Only the youngest pending writer of a register decides read stalls and write ordering.
- R6: Each source is reported ready for capture (`rd_a`, `rd_b`) once per instruction, in the first decode cycle in which it is available. A source that is free at decode is captured in the first cycle even when the other source stalls.
- R7: Independent instructions on the same unit issue back to back without stall.
- R8: Register 0 and instructions with `id_wen`=0 create no pending write. A source of register 0 never stalls.
- R9: After reset no register is pending: no stall, no writeback, no writeback delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| id_valid | input | 1 | decode holds an instruction |
| id_unit | input | 2 | functional unit code (R1) |
| id_wen | input | 1 | instruction writes a register |
| id_dst | input | 5 | destination register |
| id_src_a | input | 5 | first source register (0 = none) |
| id_src_b | input | 5 | second source register (0 = none) |
| stall_id | output | 1 | hold fetch and decode, bubble into execute |
| stall_wb | output | 1 | some writer is being held before writeback |
| issue | output | 1 | decode instruction leaves this cycle |
| fwd_hit | output | 1 | this issue depends on a forwarded result |
| rd_a | output | 1 | capture first source now |
| rd_b | output | 1 | capture second source now |
| wb_mask | output | 32 | one bit per register written back this cycle |

## Verification
The assertions take for granted that decode keeps presenting the same instruction with `id_valid` high for as long as `stall_id` is high, and only replaces it after a cycle with `issue`. The bench task that drives an instruction holds every decode input steady until it samples `stall_id` low. Only then does it advance, and it drops `id_valid` only in idle gaps. Between unrelated sequences the bench idles long enough for every record to drain, so that each expected stall count depends only on the sequence under test.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        U_ALU = 2'd0,
        U_MUL = 2'd1,
        U_DIV = 2'd2,
        U_RSV = 2'd3
    } unit_e;

    localparam int LAT_ALU   = 3;
    localparam int LAT_MUL   = 5;
    localparam int LAT_DIV   = 8;
    localparam int PIPE_TAIL = 2;   // memory + writeback stages after execute
    localparam int MAX_DIST  = LAT_DIV + PIPE_TAIL;
    localparam int CNT_W     = $clog2(MAX_DIST + 1);

    typedef logic [CNT_W-1:0] dist_t;

    // Per-register record: distance to writeback of the youngest writer,
    // and how many of those cycles are writeback hold cycles.
    typedef struct packed {
        dist_t cnt;
        dist_t dly;
    } rec_t;

    function automatic dist_t wb_dist(unit_e u);
        case (u)
            U_MUL:   return dist_t'(LAT_MUL + PIPE_TAIL);
            U_DIV:   return dist_t'(LAT_DIV + PIPE_TAIL);
            default: return dist_t'(LAT_ALU + PIPE_TAIL);
        endcase
    endfunction

    function automatic dist_t dist_max(dist_t x, dist_t y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard
    import hz_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_en,
    input  logic [AW-1:0]         alloc_reg,
    input  rec_t                  alloc_rec,
    output rec_t [NREG-1:0]       recs
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign recs[g] = '0;
        end else begin : g_live
            rec_t r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= '0;
                end else if (alloc_en && alloc_reg == AW'(g)) begin
                    r <= alloc_rec;
                end else if (r.cnt != '0) begin
                    r.cnt <= r.cnt - 1'b1;
                end
            end
            assign recs[g] = r;
        end
    end

endmodule

// File: rtl/hz_hazard_eval.sv
module hz_hazard_eval
    import hz_pkg::*;
#(
    parameter int NREG   = 32,
    parameter bit FWD_EN = 1'b1,
    localparam int AW    = $clog2(NREG)
) (
    input  logic                  valid,
    input  unit_e                 unit,
    input  logic                  wen,
    input  logic [AW-1:0]         dst,
    input  logic [AW-1:0]         src_a,
    input  logic [AW-1:0]         src_b,
    input  dist_t [NREG-1:0]      cnts,
    input  logic                  cap_a,
    input  logic                  cap_b,
    output logic                  stall_id,
    output logic                  issue,
    output logic                  fwd_hit,
    output logic                  rd_a,
    output logic                  rd_b,
    output logic                  alloc_en,
    output logic [AW-1:0]         alloc_reg,
    output rec_t                  alloc_rec
);

    // Largest remaining distance at which a source may be consumed.
    localparam dist_t THR = FWD_EN ? dist_t'(PIPE_TAIL + 1) : dist_t'(1);

    dist_t ca, cb, nat, cd;
    logic  need_a, need_b, ok_a, ok_b;

    always_comb begin
        need_a   = (src_a != '0);
        need_b   = (src_b != '0);
        ca       = cnts[src_a];
        cb       = cnts[src_b];
        ok_a     = !need_a || (ca <= THR);
        ok_b     = !need_b || (cb <= THR);
        stall_id = valid && !(ok_a && ok_b);
        issue    = valid && ok_a && ok_b;
        fwd_hit  = issue && ((need_a && ca > dist_t'(1)) || (need_b && cb > dist_t'(1)));
        rd_a     = valid && ok_a && !cap_a;
        rd_b     = valid && ok_b && !cap_b;

        nat           = wb_dist(unit);
        cd            = cnts[dst];
        alloc_en      = issue && wen && (dst != '0);
        alloc_reg     = dst;
        alloc_rec.cnt = dist_max(nat, cd);
        alloc_rec.dly = alloc_rec.cnt - nat;
    end

endmodule

// File: rtl/hz_wb_order.sv
module hz_wb_order
    import hz_pkg::*;
#(
    parameter int NREG = 32
) (
    input  rec_t [NREG-1:0]  recs,
    output logic [NREG-1:0]  wb_mask,
    output logic             stall_wb
);

    logic [NREG-1:0] hold;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign wb_mask[g] = (recs[g].cnt == dist_t'(1));
        assign hold[g]    = (recs[g].dly != '0) && (recs[g].cnt >= dist_t'(2))
                            && ((recs[g].cnt - 1'b1) <= recs[g].dly);
    end

    assign stall_wb = |hold;

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int NREG   = 32,
    parameter bit FWD_EN = 1'b1,
    localparam int AW    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [1:0]       id_unit,
    input  logic             id_wen,
    input  logic [AW-1:0]    id_dst,
    input  logic [AW-1:0]    id_src_a,
    input  logic [AW-1:0]    id_src_b,
    output logic             stall_id,
    output logic             stall_wb,
    output logic             issue,
    output logic             fwd_hit,
    output logic             rd_a,
    output logic             rd_b,
    output logic [NREG-1:0]  wb_mask
);

    rec_t  [NREG-1:0] recs;
    dist_t [NREG-1:0] cnts;
    logic             alloc_en;
    logic [AW-1:0]    alloc_reg;
    rec_t             alloc_rec;
    logic             cap_a, cap_b;

    for (genvar g = 0; g < NREG; g++) begin : g_cnt
        assign cnts[g] = recs[g].cnt;
    end

    // Sources already latched for the instruction waiting in decode.
    always_ff @(posedge clk) begin
        if (rst || issue || !id_valid) begin
            cap_a <= 1'b0;
            cap_b <= 1'b0;
        end else begin
            cap_a <= cap_a | rd_a;
            cap_b <= cap_b | rd_b;
        end
    end

    hz_hazard_eval #(.NREG(NREG), .FWD_EN(FWD_EN)) u_eval (
        .valid     (id_valid),
        .unit      (unit_e'(id_unit)),
        .wen       (id_wen),
        .dst       (id_dst),
        .src_a     (id_src_a),
        .src_b     (id_src_b),
        .cnts      (cnts),
        .cap_a     (cap_a),
        .cap_b     (cap_b),
        .stall_id  (stall_id),
        .issue     (issue),
        .fwd_hit   (fwd_hit),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .alloc_en  (alloc_en),
        .alloc_reg (alloc_reg),
        .alloc_rec (alloc_rec)
    );

    hz_scoreboard #(.NREG(NREG)) u_sb (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_en),
        .alloc_reg (alloc_reg),
        .alloc_rec (alloc_rec),
        .recs      (recs)
    );

    hz_wb_order #(.NREG(NREG)) u_wb (
        .recs      (recs),
        .wb_mask   (wb_mask),
        .stall_wb  (stall_wb)
    );

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
    parameter int NREG = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            id_valid,
    input logic            stall_id,
    input logic            stall_wb,
    input logic            issue,
    input logic            fwd_hit,
    input logic            rd_a,
    input logic            rd_b,
    input logic [NREG-1:0] wb_mask
);

    p_idle_no_stall_r2: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !stall_id);

    p_fwd_on_issue_r3: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> issue);

    p_wb_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_mask != '0) |=> ((wb_mask & $past(wb_mask)) == '0));

    p_capture_once_a_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_a && !issue) |=> !rd_a);

    p_capture_once_b_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_b && !issue) |=> !rd_b);

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wb_mask == '0 && !stall_wb));

endmodule

bind hz_interlock hz_interlock_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .id_valid (id_valid),
    .stall_id (stall_id),
    .stall_wb (stall_wb),
    .issue    (issue),
    .fwd_hit  (fwd_hit),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .wb_mask  (wb_mask)
);

// File: tb/tb_hz_interlock.sv
module tb_hz_interlock;

    localparam int CLK_PERIOD = 10;
    localparam int DRAIN      = 14;

    typedef struct packed {
        logic       gap;
        logic [1:0] unit;
        logic       wen;
        logic [4:0] dst;
        logic [4:0] a;
        logic [4:0] b;
        logic [3:0] st_fwd;
        logic [3:0] st_nof;
    } row_t;

    // gap, unit, wen, dst, src_a, src_b, stalls with forwarding, without
    localparam row_t TBL [11] = '{
        '{1'b1, 2'd1, 1'b1, 5'd1,  5'd2,  5'd3,  4'd0, 4'd0},  // mul r1
        '{1'b0, 2'd0, 1'b1, 5'd3,  5'd1,  5'd0,  4'd4, 4'd6},  // add r3<-r1 (R2,R3)
        '{1'b1, 2'd2, 1'b1, 5'd2,  5'd4,  5'd6,  4'd0, 4'd0},  // div r2
        '{1'b0, 2'd0, 1'b1, 5'd8,  5'd2,  5'd10, 4'd7, 4'd9},  // add r8<-r2,r10 (R3)
        '{1'b0, 2'd0, 1'b1, 5'd10, 5'd11, 5'd12, 4'd0, 4'd0},  // sub r10 (R6)
        '{1'b1, 2'd1, 1'b1, 5'd5,  5'd0,  5'd0,  4'd0, 4'd0},  // mul r5
        '{1'b0, 2'd1, 1'b1, 5'd6,  5'd0,  5'd0,  4'd0, 4'd0},  // mul r6 (R7)
        '{1'b1, 2'd0, 1'b0, 5'd7,  5'd0,  5'd0,  4'd0, 4'd0},  // no write r7
        '{1'b0, 2'd0, 1'b1, 5'd9,  5'd7,  5'd0,  4'd0, 4'd0},  // read r7 (R8)
        '{1'b1, 2'd2, 1'b1, 5'd0,  5'd1,  5'd2,  4'd0, 4'd0},  // div to r0
        '{1'b0, 2'd0, 1'b1, 5'd11, 5'd0,  5'd0,  4'd0, 4'd0}   // read r0 (R8)
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v   [2];
    logic [1:0]  un  [2];
    logic        we  [2];
    logic [4:0]  ds  [2];
    logic [4:0]  sa  [2];
    logic [4:0]  sb  [2];
    logic        st_id [2];
    logic        st_wb [2];
    logic        iss   [2];
    logic        fh    [2];
    logic        ra    [2];
    logic        rb    [2];
    logic [31:0] wbm   [2];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    int last_wb [32];
    int wbn [32];
    int swb_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hz_interlock #(.NREG(32), .FWD_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .id_valid(v[0]), .id_unit(un[0]), .id_wen(we[0]),
        .id_dst(ds[0]), .id_src_a(sa[0]), .id_src_b(sb[0]),
        .stall_id(st_id[0]), .stall_wb(st_wb[0]), .issue(iss[0]), .fwd_hit(fh[0]),
        .rd_a(ra[0]), .rd_b(rb[0]), .wb_mask(wbm[0]));

    hz_interlock #(.NREG(32), .FWD_EN(1'b0)) dut_nf (
        .clk(clk), .rst(rst), .id_valid(v[1]), .id_unit(un[1]), .id_wen(we[1]),
        .id_dst(ds[1]), .id_src_a(sa[1]), .id_src_b(sb[1]),
        .stall_id(st_id[1]), .stall_wb(st_wb[1]), .issue(iss[1]), .fwd_hit(fh[1]),
        .rd_a(ra[1]), .rd_b(rb[1]), .wb_mask(wbm[1]));

    // Writeback observation on the forwarding instance (registered outputs).
    always @(negedge clk) begin
        for (int g = 0; g < 32; g++) begin
            if (wbm[0][g]) begin
                last_wb[g] = cyc;
                wbn[g] = wbn[g] + 1;
            end
        end
        if (st_wb[0]) swb_cnt = swb_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        for (int g = 0; g < 32; g++) begin
            last_wb[g] = -1;
            wbn[g] = 0;
        end
        swb_cnt = 0;
    endtask

    task automatic idle(input int s, input int n);
        @(negedge clk);
        v[s] = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic run(input int s, input int unit, input bit wen, input int dst,
                       input int a, input int b, output int stalls,
                       output bit ra_first, output bit rb_first, output bit fhit,
                       output int na, output int nb, output int icyc);
        @(negedge clk);
        v[s] = 1'b1; un[s] = 2'(unit); we[s] = wen;
        ds[s] = 5'(dst); sa[s] = 5'(a); sb[s] = 5'(b);
        #1;
        ra_first = ra[s];
        rb_first = rb[s];
        stalls = 0; na = 0; nb = 0;
        while (st_id[s]) begin
            na += int'(ra[s]); nb += int'(rb[s]);
            stalls++;
            @(negedge clk);
            #1;
        end
        na += int'(ra[s]); nb += int'(rb[s]);
        fhit = fh[s];
        icyc = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int st, na, nb, i0, i1, i2;
        bit fa, fb, fx;
        for (int s = 0; s < 2; s++) begin
            v[s] = 0; un[s] = 0; we[s] = 0; ds[s] = 0; sa[s] = 0; sb[s] = 0;
        end
        clear_obs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R9: reset state
        check(!st_id[0] && !st_id[1], "R9 stall_id after reset", int'(st_id[0]), 0);
        check(!st_wb[0] && wbm[0] == 0 && wbm[1] == 0, "R9 wb idle after reset",
              int'(wbm[0] != 0), 0);

        // Table walk on both builds
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 11; r++) begin
                if (TBL[r].gap) idle(s, DRAIN);
                run(s, int'(TBL[r].unit), TBL[r].wen, int'(TBL[r].dst), int'(TBL[r].a),
                    int'(TBL[r].b), st, fa, fb, fx, na, nb, i0);
                check(st == int'(s == 0 ? TBL[r].st_fwd : TBL[r].st_nof),
                      $sformatf("R2/R3/R7/R8 row %0d build %0d stalls", r, s), st,
                      int'(s == 0 ? TBL[r].st_fwd : TBL[r].st_nof));
                if (s == 1) check(!fx, "R3 no forward hit without forwarding", int'(fx), 0);
            end
            idle(s, DRAIN);
        end

        // R1: writeback distance for each unit
        clear_obs();
        run(0, 0, 1, 2, 0, 0, st, fa, fb, fx, na, nb, i0);
        idle(0, DRAIN);
        check(last_wb[2] == i0 + 5, "R1 add writeback distance", last_wb[2] - i0, 5);
        run(0, 1, 1, 3, 0, 0, st, fa, fb, fx, na, nb, i0);
        idle(0, DRAIN);
        check(last_wb[3] == i0 + 7, "R1 mul writeback distance", last_wb[3] - i0, 7);
        run(0, 2, 1, 4, 0, 0, st, fa, fb, fx, na, nb, i0);
        idle(0, DRAIN);
        check(last_wb[4] == i0 + 10, "R1 div writeback distance", last_wb[4] - i0, 10);
        check(wbn[0] == 0, "R8 register 0 never written back", wbn[0], 0);

        // R4: mul r1 then add r1, add must write back after mul
        clear_obs();
        run(0, 1, 1, 1, 2, 3, st, fa, fb, fx, na, nb, i0);
        run(0, 0, 1, 1, 5, 6, st, fa, fb, fx, na, nb, i1);
        check(st == 0, "R4 second writer does not stall decode", st, 0);
        idle(0, DRAIN);
        check(last_wb[1] == i0 + 8, "R4 delayed writeback after older writer",
              last_wb[1] - i0, 8);
        check(swb_cnt == 2, "R4 writeback hold cycles", swb_cnt, 2);
        check(wbn[1] == 1, "R4 single final write in program order", wbn[1], 1);

        // R5: add r1 then div r1; reader of r1 waits for the div
        clear_obs();
        run(0, 0, 1, 1, 0, 0, st, fa, fb, fx, na, nb, i0);
        run(0, 2, 1, 1, 0, 0, st, fa, fb, fx, na, nb, i1);
        run(0, 0, 1, 3, 1, 0, st, fa, fb, fx, na, nb, i2);
        check(st == 7, "R5 reader follows youngest writer", st, 7);
        check(fx, "R3 forward hit on early issue", int'(fx), 1);
        idle(0, DRAIN);
        check(last_wb[1] == i1 + 10, "R5 final write to r1 from youngest",
              last_wb[1] - i1, 10);

        // R6: div r2; add r8<-r2,r10; sub r10
        run(0, 2, 1, 2, 4, 6, st, fa, fb, fx, na, nb, i0);
        run(0, 0, 1, 8, 2, 10, st, fa, fb, fx, na, nb, i1);
        check(!fa && fb, "R6 free source captured at first decode cycle",
              int'({fa, fb}), 1);
        check(na == 1 && nb == 1, "R6 each source captured once", na * 10 + nb, 11);
        run(0, 0, 1, 10, 11, 12, st, fa, fb, fx, na, nb, i2);
        check(st == 0, "R6 later writer of captured source not held", st, 0);
        idle(0, DRAIN);
        check(last_wb[8] < last_wb[10] || last_wb[8] == i1 + 5,
              "R6 add result written", last_wb[8] - i1, 5);

        // R9: reset while records are pending
        run(0, 2, 1, 5, 0, 0, st, fa, fb, fx, na, nb, i0);
        @(negedge clk);
        v[0] = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        clear_obs();
        run(0, 0, 1, 6, 5, 0, st, fa, fb, fx, na, nb, i1);
        check(st == 0, "R9 reset clears pending writers", st, 0);
        idle(0, DRAIN);
        check(wbn[5] == 0, "R9 no writeback of flushed writer", wbn[5], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule